// File: doc/BRIEF.md
# Timed Byte-Wide Bit-Bang Port

This block turns eight serial-interface lines into a general-purpose parallel port. Bytes arrive on a valid/ready input stream and wait in a small FIFO. They are then driven onto the pins one at a time, at a pace set by a programmable prescaler. The pins are read back into a valid/ready output stream. A per-line direction mask chooses which lines are driven and which are left floating. Two active-low strobes go out with the pins, one for writes and one for reads, so that external logic can clock on each access.

In asynchronous mode the write and read sides run independently. A queued byte is driven whenever the write strobe is idle at a prescaler tick. The pins are sampled on every other tick whether or not anything was written, and the newest sample replaces any sample that has not been taken.

In synchronous mode every write is followed by exactly one read. The sample is taken one prescaler period after the pins change. The next write waits until the consumer has taken that sample, so no sample is ever lost.

Top module: `bitbang_port`

## Requirements
- R1: While reset is held and just after it, both strobes are high, `out_valid` is 0, `pin_o` is 0x00 and `in_ready` is 1.
- R2: The prescaler ticks once every `prescale`+1 clocks. Each strobe pulse stays low for exactly `prescale`+1 clocks, which is a single clock when `prescale` is 0.
- R3: Queued bytes appear on `pin_o` in arrival order. `pin_o` changes only on the clock at which `wr_n` falls. `wr_n` never falls while the FIFO is empty.
- R4: In asynchronous mode with bytes queued, consecutive falling edges of `wr_n` are 2·(`prescale`+1) clocks apart.
- R5: In asynchronous mode, `rd_n` falls every 2·(`prescale`+1) clocks. On each falling edge, `out_data` takes the value of `pin_i` and `out_valid` becomes 1. `out_valid` rises only together with a falling edge of `rd_n`.
- R6: In asynchronous mode, a sample that has not been taken is replaced by the newest sample.
- R7: In synchronous mode, each write produces exactly one sample. `rd_n` falls on the same clock at which `wr_n` rises, and the two strobes are never low together. The sample holds the pin state left by that write: driven bits from the byte, undriven bits from outside.
- R8: In synchronous mode, while a sample is waiting in `out_data` (`out_valid`=1), no new write starts, and the queued bytes stay in the FIFO.
- R9: `pin_oe` equals `dir_mask`. A bit at 1 drives that line and a bit at 0 leaves it tri-stated.
- R10: `in_ready` is 0 while the FIFO holds DEPTH bytes (4 by default). It returns to 1 once a byte has been popped.
- R11: In synchronous mode, while `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| prescale | input | PW | Tick period minus one, in clocks |
| dir_mask | input | W | Per-line drive enable, 1 means drive |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | W | Byte to drive |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer takes the sample |
| out_data | output | W | Sampled pin value |
| pin_o | output | W | Output value of the lines |
| pin_oe | output | W | Output enable of the lines |
| pin_i | input | W | Observed state of the lines |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The assertions are evaluated on every clock. They check that the pins change only together with a falling `wr_n`, and that a new sample always comes with a falling `rd_n`. In synchronous mode they check that the read strobe takes over exactly where the write strobe ends, that no write starts while a sample is pending, and that a stalled sample stays stable. The remaining behaviour can only be shown by the bench scenarios: strobe widths and spacing for a given prescaler, including zero, the order of the driven bytes, replacement of samples in asynchronous mode, the mix of driven and outside bits in a synchronous read, and the FIFO-full backpressure.

// File: rtl/bitbang_port.sv
module bitbang_port #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int PW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sync,
  input  logic [PW-1:0] prescale,
  input  logic [W-1:0]  dir_mask,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  pin_i,
  output logic          wr_n,
  output logic          rd_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD} phase_t;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic [PW-1:0] div;
  logic          tick, push, pop, samp;
  phase_t        ph;

  assign tick     = (div >= prescale);
  assign in_ready = (fill != CW'(DEPTH));
  assign push     = in_valid && in_ready;
  assign pin_oe   = dir_mask;

  always_comb begin
    pop = 1'b0;
    if (tick && fill != '0) begin
      if (mode_sync) pop = (ph == PH_IDLE) && !out_valid;
      else           pop = wr_n;
    end
  end

  assign samp = tick && (mode_sync ? (ph == PH_WR) : rd_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= tick ? '0 : div + 1'b1;

  always_ff @(posedge clk)
    if (push) mem[wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= '0;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      ph    <= PH_IDLE;
    end else if (tick) begin
      if (pop) pin_o <= mem[rp];
      if (!wr_n)     wr_n <= 1'b1;
      else if (pop)  wr_n <= 1'b0;
      if (!rd_n)     rd_n <= 1'b1;
      else if (samp) rd_n <= 1'b0;
      if (!mode_sync) ph <= PH_IDLE;
      else begin
        case (ph)
          PH_IDLE: if (pop) ph <= PH_WR;
          PH_WR:   ph <= PH_RD;
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (samp) begin
      out_valid <= 1'b1;
      out_data  <= pin_i;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module bitbang_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_sync,
  input logic         wr_n,
  input logic         rd_n,
  input logic [W-1:0] pin_o,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  assert_pin_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> $fell(wr_n));

  assert_sample_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $fell(rd_n));

  assert_sync_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && $rose(wr_n)) |-> $fell(rd_n));

  assert_sync_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync |-> (wr_n || rd_n));

  assert_sync_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && $fell(wr_n)) |-> !out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bitbang_port bitbang_port_chk #(.W(W)) u_chk (.*);

// File: tb/bitbang_port_tb.sv
module bitbang_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 0, rst_n = 0, mode_sync = 0;
  logic [15:0] prescale = 0;
  logic [7:0] dir_mask = 0, in_data = 0, ext = 0;
  logic in_valid = 0, out_ready = 0;
  wire in_ready, out_valid, wr_n, rd_n;
  wire [7:0] out_data, pin_o, pin_oe, pin_i;

  assign pin_i = (pin_o & pin_oe) | (ext & ~pin_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  bitbang_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .prescale(prescale),
    .dir_mask(dir_mask), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pin_o(pin_o), .pin_oe(pin_oe), .pin_i(pin_i), .wr_n(wr_n), .rd_n(rd_n));

  int checks = 0, fails = 0;

  int cyc, wr_run, wr_len, wr_pulses, wr_fall_cyc, wr_gap, pin_bad;
  int rd_run, rd_len, rd_pulses, rd_fall_cyc, rd_gap, sync_ok, sync_bad, out_n;
  logic prev_wr, prev_rd;
  logic [7:0] prev_pin, rd_samp;
  logic [7:0] wr_log [16];
  logic [7:0] out_log [16];

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; wr_run = 0; wr_len = 0; wr_pulses = 0; wr_fall_cyc = 0; wr_gap = 0;
      pin_bad = 0; rd_run = 0; rd_len = 0; rd_pulses = 0; rd_fall_cyc = 0; rd_gap = 0;
      sync_ok = 0; sync_bad = 0; out_n = 0; prev_wr = 1; prev_rd = 1;
      prev_pin = pin_o; rd_samp = 0;
    end else begin
      cyc++;
      if (!wr_n) wr_run = prev_wr ? 1 : wr_run + 1;
      if (!prev_wr && wr_n) wr_len = wr_run;
      if (prev_wr && !wr_n) begin
        if (wr_pulses < 16) wr_log[wr_pulses] = pin_o;
        if (wr_pulses > 0) wr_gap = cyc - wr_fall_cyc;
        wr_fall_cyc = cyc;
        wr_pulses++;
      end else if (pin_o != prev_pin) pin_bad++;
      if (!rd_n) rd_run = prev_rd ? 1 : rd_run + 1;
      if (!prev_rd && rd_n) rd_len = rd_run;
      if (prev_rd && !rd_n) begin
        rd_samp = out_data;
        if (rd_pulses > 0) rd_gap = cyc - rd_fall_cyc;
        rd_fall_cyc = cyc;
        rd_pulses++;
        if (mode_sync) begin
          if (!prev_wr && wr_n) sync_ok++;
          else sync_bad++;
        end
      end
      if (out_valid && out_ready) begin
        if (out_n < 16) out_log[out_n] = out_data;
        out_n++;
      end
      prev_wr = wr_n; prev_rd = rd_n; prev_pin = pin_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic sync, input int p, input logic [7:0] dir);
    @(negedge clk);
    rst_n = 0; mode_sync = sync; prescale = 16'(p); dir_mask = dir;
    in_valid = 0; out_ready = 0;
    wait_cycles(3);
    rst_n = 1;
  endtask

  task automatic push_byte(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    do_reset(0, 5, 8'h00);
    check(wr_n == 1, "R1", "wr_n after reset", int'(wr_n), 1);
    check(rd_n == 1, "R1", "rd_n after reset", int'(rd_n), 1);
    check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(pin_o == 8'h00, "R1", "pin_o after reset", int'(pin_o), 0);
    check(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_oe;
    dir_mask = 8'h5A; #1;
    check(pin_oe == 8'h5A, "R9", "pin_oe", int'(pin_oe), 'h5A);
    dir_mask = 8'hC3; #1;
    check(pin_oe == 8'hC3, "R9", "pin_oe", int'(pin_oe), 'hC3);
  endtask

  task automatic t_async_write;
    do_reset(0, 3, 8'hFF);
    out_ready = 1;
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    wait_cycles(40);
    check(wr_pulses == 3, "R3", "write pulse count", wr_pulses, 3);
    check(wr_log[0] == 8'h11, "R3", "first driven byte", int'(wr_log[0]), 'h11);
    check(wr_log[1] == 8'h22, "R3", "second driven byte", int'(wr_log[1]), 'h22);
    check(wr_log[2] == 8'h33, "R3", "third driven byte", int'(wr_log[2]), 'h33);
    check(pin_bad == 0, "R3", "pin changes without wr_n fall", pin_bad, 0);
    check(wr_len == 4, "R2", "wr_n low width p=3", wr_len, 4);
    check(wr_gap == 8, "R4", "wr_n fall spacing p=3", wr_gap, 8);
  endtask

  task automatic t_presc_zero;
    do_reset(0, 0, 8'hFF);
    out_ready = 1;
    push_byte(8'hA0); push_byte(8'h0B);
    wait_cycles(20);
    check(wr_pulses == 2, "R2", "write pulse count p=0", wr_pulses, 2);
    check(wr_len == 1, "R2", "wr_n low width p=0", wr_len, 1);
    check(wr_log[1] == 8'h0B, "R3", "second byte p=0", int'(wr_log[1]), 'h0B);
  endtask

  task automatic t_async_read;
    do_reset(0, 2, 8'h00);
    ext = 8'hA5; out_ready = 1;
    wait_cycles(30);
    check(rd_pulses >= 3, "R5", "read pulses occur", rd_pulses, 3);
    check(rd_samp == 8'hA5, "R5", "sampled value", int'(rd_samp), 'hA5);
    check(rd_len == 3, "R2", "rd_n low width p=2", rd_len, 3);
    check(rd_gap == 6, "R5", "rd_n fall spacing p=2", rd_gap, 6);
    check(wr_pulses == 0, "R3", "no write with empty FIFO", wr_pulses, 0);
  endtask

  task automatic t_overwrite;
    do_reset(0, 2, 8'h00);
    ext = 8'h11; out_ready = 0;
    while (rd_pulses < 1) @(negedge clk);
    check(out_data == 8'h11, "R6", "first sample", int'(out_data), 'h11);
    ext = 8'h22;
    while (rd_pulses < 3) @(negedge clk);
    check(out_valid == 1, "R6", "sample still valid", int'(out_valid), 1);
    check(out_data == 8'h22, "R6", "newest sample replaces old", int'(out_data), 'h22);
  endtask

  task automatic t_sync;
    do_reset(1, 2, 8'h0F);
    ext = 8'h90; out_ready = 1;
    push_byte(8'h03); push_byte(8'h05); push_byte(8'h0C);
    wait_cycles(60);
    check(out_n == 3, "R7", "one sample per write", out_n, 3);
    check(rd_pulses == 3, "R7", "read pulse count", rd_pulses, 3);
    check(out_log[0] == 8'h93, "R7", "sample 0", int'(out_log[0]), 'h93);
    check(out_log[1] == 8'h95, "R7", "sample 1", int'(out_log[1]), 'h95);
    check(out_log[2] == 8'h9C, "R7", "sample 2", int'(out_log[2]), 'h9C);
    check(sync_ok == 3 && sync_bad == 0, "R7", "rd_n falls as wr_n rises", sync_ok, 3);
    check(rd_len == 3, "R2", "sync rd_n low width", rd_len, 3);
  endtask

  task automatic t_stall;
    do_reset(1, 1, 8'hFF);
    out_ready = 0;
    push_byte(8'h41); push_byte(8'h42); push_byte(8'h43);
    wait_cycles(40);
    check(wr_pulses == 1, "R8", "writes stall while sample waits", wr_pulses, 1);
    check(out_valid == 1, "R11", "sample held valid", int'(out_valid), 1);
    check(out_data == 8'h41, "R11", "sample held stable", int'(out_data), 'h41);
    out_ready = 1;
    wait_cycles(40);
    check(out_n == 3, "R8", "no sample lost after stall", out_n, 3);
    check(out_log[0] == 8'h41, "R8", "stalled sample delivered", int'(out_log[0]), 'h41);
    check(out_log[2] == 8'h43, "R8", "last sample", int'(out_log[2]), 'h43);
  endtask

  task automatic t_full;
    do_reset(1, 50, 8'hFF);
    out_ready = 0;
    push_byte(8'h01); push_byte(8'h02); push_byte(8'h03); push_byte(8'h04);
    check(in_ready == 0, "R10", "in_ready low when FIFO full", int'(in_ready), 0);
    while (wr_pulses < 1) @(negedge clk);
    check(in_ready == 1, "R10", "in_ready back after pop", int'(in_ready), 1);
  endtask

  initial begin
    t_reset();
    t_oe();
    t_async_write();
    t_presc_zero();
    t_async_read();
    t_overwrite();
    t_sync();
    t_stall();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule